// File: doc/BRIEF.md
# Timestamp Event Interrupt Status Unit

This block gathers the interrupt sources of a precision-time subsystem into one small status register and a single interrupt line. It watches a free-running time value against a programmable target, two external capture pins, and a pulse from the packet path. Each source sets its own sticky status flag. Software reads the flags and clears them by writing ones back.

The target is written as two 32-bit words. The upper word is held in a staging register. A write of the lower word commits both halves at once and re-arms the comparison. The target flag sets when the time value first reaches or passes the target. Each capture pin is synchronized and then filtered, so that only a level held for a minimum number of cycles counts. A capture event fires on the transition into the pin's selected active level. Where enabled, a pin event also clears the target flag. The interrupt line is the OR of the status flags that are enabled by a mask.

Top module: `tsi_event_unit`

## Requirements
- R1: Out of reset `sts_o` is all zero and `irq_o` is 0.
- R2: A one-cycle `tx_match_i` pulse sets status bit 3 (the top bit) at the next clock edge.
- R3: A qualified active edge on pin index 0 sets status bit 1, and on pin index 1 sets status bit 2. A level held after the edge does not set the bit again once software has cleared it.
- R4: A pin excursion counts only if the synchronized level stays at the new value for at least `FILT_LEN` consecutive cycles. Shorter excursions set nothing.
- R5: `pin_pol_i[p]`=1 makes a low-to-high transition the active edge of pin p. `pin_pol_i[p]`=0 makes a high-to-low transition the active edge.
- R6: Status bit 0 sets on the cycle in which the unsigned condition time >= target becomes true. It does not set again while that condition stays true.
- R7: Writing the high word alone does not change the compare. Writing the low word loads {staged high, low} and re-arms the compare. Before the first low-word write, bit 0 never sets.
- R8: A write with `sts_we_i`=1 clears each status bit whose `sts_wdata_i` bit is 1. Bits written with 0 keep their value.
- R9: When a set condition and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: A qualified pin event with `clr_en_i[p]`=1 clears status bit 0. With `clr_en_i[p]`=0 the same event leaves bit 0 unchanged.
- R11: `irq_o` equals the OR over `sts_o & irq_en_i`.
- R12: With `cap_en_i[p]`=0, events on pin p do not set that pin's status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Free-running time value |
| tgt_hi_we_i | input | 1 | Write strobe for the staged high target word |
| tgt_lo_we_i | input | 1 | Write strobe for the low target word; commits the target |
| tgt_wdata_i | input | 32 | Target write data |
| pin_i | input | 2 | Asynchronous capture pins (index 1 maps to bit 2, index 0 to bit 1) |
| pin_pol_i | input | 2 | Active edge per pin: 1 for rising, 0 for falling |
| cap_en_i | input | 2 | Per-pin enable for setting the status bit |
| clr_en_i | input | 2 | Per-pin enable for clearing the target flag |
| tx_match_i | input | 1 | Pulse: host transmit packet matched |
| sts_we_i | input | 1 | Status write strobe (write-one-to-clear) |
| sts_wdata_i | input | 4 | Status write data |
| irq_en_i | input | 4 | Interrupt enable mask |
| sts_o | output | 4 | Status: bit3 transmit, bit2 pin 1, bit1 pin 0, bit0 target |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the unit with `FILT_LEN`=3, two synchronizer stages and the full 64-bit time width. The short filter lets a pulse exactly at the minimum width, and one cycle short of it, be driven within a few cycles. The full width lets random targets around a high-word carry exercise the unsigned comparison at and across equality. The 4-bit status matches the register layout, so each field position and the set-wins and clear-by-pin interactions are tested as they will be used.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int unsigned TIMER_BIT    = 0;
  localparam int unsigned PIN_BASE_BIT = 1;
endpackage

// File: rtl/tsi_pin_filter.sv
module tsi_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic evt_o
);
  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   raw;
  logic                   flip;

  assign raw  = sync_q[SYNC_STAGES-1];
  assign flip = (raw != lvl_q) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  // level must differ from the filtered value for FILT_LEN samples in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      evt_o <= 1'b0;
    end else begin
      evt_o <= flip && (raw == pol_i);
      if (raw == lvl_q) begin
        cnt_q <= '0;
      end else if (flip) begin
        lvl_q <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsi_target_cmp.sv
module tsi_target_cmp #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              hit_o
);
  localparam int unsigned HI_W = TIME_W - WORD_W;

  logic [HI_W-1:0]   hi_stage_q;
  logic [TIME_W-1:0] tgt_q;
  logic              armed_q;
  logic              ge_prev_q;
  logic              ge_now;

  assign ge_now = armed_q && (time_i >= tgt_q);
  assign hit_o  = ge_now && !ge_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_stage_q <= '0;
      tgt_q      <= '0;
      armed_q    <= 1'b0;
      ge_prev_q  <= 1'b0;
    end else begin
      if (hi_we_i) hi_stage_q <= wdata_i[HI_W-1:0];
      if (lo_we_i) begin
        tgt_q     <= {hi_stage_q, wdata_i};
        armed_q   <= 1'b1;
        ge_prev_q <= 1'b0;  // re-arm: next compare may fire again
      end else begin
        ge_prev_q <= ge_now;
      end
    end
  end
endmodule

// File: rtl/tsi_status_reg.sv
module tsi_status_reg #(
  parameter int unsigned STS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] set_i,
  input  logic [STS_W-1:0] hw_clr_i,
  input  logic             we_i,
  input  logic [STS_W-1:0] wdata_i,
  input  logic [STS_W-1:0] irq_en_i,
  output logic [STS_W-1:0] sts_o,
  output logic             irq_o
);
  logic [STS_W-1:0] sw_clr;
  logic [STS_W-1:0] sts_d;

  assign sw_clr = we_i ? wdata_i : '0;
  // set takes priority over any clear
  assign sts_d  = (sts_o & ~sw_clr & ~hw_clr_i) | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_o <= '0;
    else         sts_o <= sts_d;
  end

  assign irq_o = |(sts_o & irq_en_i);
endmodule

// File: rtl/tsi_event_unit.sv
module tsi_event_unit #(
  parameter int unsigned TIME_W      = 64,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned N_PINS      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4,
  localparam int unsigned STS_W      = N_PINS + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              tgt_hi_we_i,
  input  logic              tgt_lo_we_i,
  input  logic [WORD_W-1:0] tgt_wdata_i,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [N_PINS-1:0] pin_pol_i,
  input  logic [N_PINS-1:0] cap_en_i,
  input  logic [N_PINS-1:0] clr_en_i,
  input  logic              tx_match_i,
  input  logic              sts_we_i,
  input  logic [STS_W-1:0]  sts_wdata_i,
  input  logic [STS_W-1:0]  irq_en_i,
  output logic [STS_W-1:0]  sts_o,
  output logic              irq_o
);
  import tsi_pkg::*;

  logic [N_PINS-1:0] pin_evt;
  logic              tgt_hit;
  logic [STS_W-1:0]  set_vec;
  logic [STS_W-1:0]  hw_clr;

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    tsi_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[p]),
      .pol_i (pin_pol_i[p]),
      .evt_o (pin_evt[p])
    );
  end

  tsi_target_cmp #(
    .TIME_W(TIME_W),
    .WORD_W(WORD_W)
  ) u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .time_i (time_i),
    .hi_we_i(tgt_hi_we_i),
    .lo_we_i(tgt_lo_we_i),
    .wdata_i(tgt_wdata_i),
    .hit_o  (tgt_hit)
  );

  always_comb begin
    set_vec = '0;
    hw_clr  = '0;
    set_vec[TIMER_BIT] = tgt_hit;
    set_vec[STS_W-1]   = tx_match_i;
    set_vec[PIN_BASE_BIT +: N_PINS] = pin_evt & cap_en_i;
    hw_clr[TIMER_BIT]  = |(pin_evt & clr_en_i);
  end

  tsi_status_reg #(
    .STS_W(STS_W)
  ) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .hw_clr_i(hw_clr),
    .we_i    (sts_we_i),
    .wdata_i (sts_wdata_i),
    .irq_en_i(irq_en_i),
    .sts_o   (sts_o),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/tsi_event_unit_chk.sv
module tsi_event_unit_chk #(
  parameter int unsigned N_PINS = 2,
  localparam int unsigned STS_W = N_PINS + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_match_i,
  input logic              sts_we_i,
  input logic [STS_W-1:0]  sts_wdata_i,
  input logic [N_PINS-1:0] cap_en_i,
  input logic [STS_W-1:0]  irq_en_i,
  input logic [STS_W-1:0]  sts_o,
  input logic              irq_o
);
  localparam int unsigned TX = STS_W - 1;

  a_r2_tx_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_match_i |=> sts_o[TX]);

  a_r9_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_match_i && sts_we_i && sts_wdata_i[TX]) |=> sts_o[TX]);

  a_r8_one_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && sts_wdata_i[TX] && !tx_match_i) |=> !sts_o[TX]);

  a_r8_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_we_i && !sts_wdata_i[TX] && sts_o[TX]) |=> sts_o[TX]);

  a_r11_irq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(sts_o & irq_en_i));

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin_chk
    a_r12_cap_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_en_i[p] |=> !$rose(sts_o[p+1]));
  end
endmodule

bind tsi_event_unit tsi_event_unit_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_match_i (tx_match_i),
  .sts_we_i   (sts_we_i),
  .sts_wdata_i(sts_wdata_i),
  .cap_en_i   (cap_en_i),
  .irq_en_i   (irq_en_i),
  .sts_o      (sts_o),
  .irq_o      (irq_o)
);

// File: tb/tsi_event_unit_tb_top.sv
`timescale 1ns/1ps
module tsi_event_unit_tb_top;
  localparam int unsigned FILT = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic [63:0] time_i = '0;
  logic        tgt_hi_we_i = 1'b0;
  logic        tgt_lo_we_i = 1'b0;
  logic [31:0] tgt_wdata_i = '0;
  logic [1:0]  pin_i = 2'b10;
  logic [1:0]  pin_pol_i = 2'b01;
  logic [1:0]  cap_en_i = 2'b11;
  logic [1:0]  clr_en_i = 2'b00;
  logic        tx_match_i = 1'b0;
  logic        sts_we_i = 1'b0;
  logic [3:0]  sts_wdata_i = '0;
  logic [3:0]  irq_en_i = '0;
  logic [3:0]  sts_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench model of the target compare and status
  logic [31:0] m_hi = '0;
  logic [63:0] m_tgt = '0;
  bit          m_armed = 0;
  bit          m_prev = 0;
  logic [3:0]  m_sts = '0;

  tsi_event_unit #(
    .TIME_W(64), .WORD_W(32), .N_PINS(2), .SYNC_STAGES(2), .FILT_LEN(FILT)
  ) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_i),
    .tgt_hi_we_i(tgt_hi_we_i), .tgt_lo_we_i(tgt_lo_we_i), .tgt_wdata_i(tgt_wdata_i),
    .pin_i(pin_i), .pin_pol_i(pin_pol_i), .cap_en_i(cap_en_i), .clr_en_i(clr_en_i),
    .tx_match_i(tx_match_i), .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
    .irq_en_i(irq_en_i), .sts_o(sts_o), .irq_o(irq_o)
  );

  always #2 clk_i = ~clk_i;

  function automatic logic [3:0] next_sts(logic [3:0] s, bit tx, bit we,
                                          logic [3:0] wd, bit hit);
    logic [3:0] clr = we ? wd : 4'b0;
    return (s & ~clr) | {tx, 2'b00, hit};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  // one modelled cycle: apply inputs, advance model, clock
  task automatic step(bit tx, bit we, logic [3:0] wd, bit hwe, bit lwe,
                      logic [31:0] wdat, logic [63:0] t);
    bit ge, hit;
    tx_match_i = tx; sts_we_i = we; sts_wdata_i = wd;
    tgt_hi_we_i = hwe; tgt_lo_we_i = lwe; tgt_wdata_i = wdat; time_i = t;
    ge  = m_armed && (t >= m_tgt);
    hit = ge && !m_prev;
    m_sts = next_sts(m_sts, tx, we, wd, hit);
    if (lwe) begin m_tgt = {m_hi, wdat}; m_armed = 1; m_prev = 0; end
    else m_prev = ge;
    if (hwe) m_hi = wdat;
    tick();
    tx_match_i = 0; sts_we_i = 0; tgt_hi_we_i = 0; tgt_lo_we_i = 0;
  endtask

  task automatic pulse(int idx, bit act_lvl, int width);
    pin_i[idx] = act_lvl;
    tick(width);
    pin_i[idx] = ~act_lvl;
    tick(FILT + 6);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1 rst_ni = 1'b0;
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    tick(4);
    check("R1 sts", 32'(sts_o), 0);
    check("R1 irq", 32'(irq_o), 0);

    // transmit match and masking
    step(1, 0, 0, 0, 0, 0, 64'd0);
    check("R2 tx bit3", 32'(sts_o), 32'h8);
    irq_en_i = 4'b0111; #1;
    check("R11 masked", 32'(irq_o), 0);
    irq_en_i = 4'b1000; #1;
    check("R11 enabled", 32'(irq_o), 1);
    step(0, 1, 4'b0111, 0, 0, 0, 64'd0);
    check("R8 zero keeps", 32'(sts_o), 32'h8);
    step(0, 1, 4'b1000, 0, 0, 0, 64'd0);
    check("R8 one clears", 32'(sts_o), 0);
    step(1, 1, 4'b1000, 0, 0, 0, 64'd0);
    check("R9 set wins", 32'(sts_o), 32'h8);
    step(0, 1, 4'b1111, 0, 0, 0, 64'd0);

    // target compare
    step(0, 0, 0, 0, 0, 0, '1);
    check("R7 unarmed", 32'(sts_o), 0);
    step(0, 0, 0, 1, 0, 32'h1, 64'h0);
    step(0, 0, 0, 0, 0, 0, '1);
    check("R7 hi only", 32'(sts_o), 0);
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 64'h0);
    step(0, 0, 0, 0, 0, 0, 64'h1_FFFF_FFFE);
    check("R6 below", 32'(sts_o), 0);
    step(0, 0, 0, 0, 0, 0, 64'h1_FFFF_FFFF);
    check("R6 equal", 32'(sts_o), 1);
    step(0, 1, 4'b0001, 0, 0, 0, 64'h2_0000_0000);
    step(0, 0, 0, 0, 0, 0, 64'h2_0000_0005);
    check("R6 no reset", 32'(sts_o), 0);
    step(0, 0, 0, 0, 1, 32'h0, 64'h2_0000_0005);
    step(0, 0, 0, 0, 0, 0, 64'h2_0000_0006);
    check("R7 rearm", 32'(sts_o), 1);

    // capture pins: pin0 active high, pin1 active low
    pulse(0, 1, FILT - 1);
    check("R4 short", 32'(sts_o), 32'h1);
    pulse(0, 1, FILT);
    check("R3 R4 pin0 bit1", 32'(sts_o), 32'h3);
    pulse(1, 0, FILT + 2);
    check("R5 pin1 falling bit2", 32'(sts_o), 32'h7);
    step(0, 1, 4'b0110, 0, 0, 0, 64'h2_0000_0006);
    pin_i[0] = 1; tick(FILT + 6);
    check("R3 edge", 32'(sts_o), 32'h3);
    step(0, 1, 4'b0010, 0, 0, 0, 64'h2_0000_0006);
    tick(FILT + 4);
    check("R3 held level", 32'(sts_o), 32'h1);
    pin_i[0] = 0; tick(FILT + 6);
    check("R5 inactive edge", 32'(sts_o), 32'h1);
    cap_en_i = 2'b10; clr_en_i = 2'b00;
    pulse(0, 1, FILT + 1);
    check("R12 gated, R10 off", 32'(sts_o), 32'h1);
    clr_en_i = 2'b01;
    pulse(0, 1, FILT + 1);
    check("R10 pin clears timer", 32'(sts_o), 32'h0);
    clr_en_i = 2'b00; cap_en_i = 2'b11;
    irq_en_i = 4'b0000;

    // random: transmit, software clears, target writes
    m_sts = sts_o;
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] t;
      bit hwe, lwe;
      t   = m_tgt + 64'($urandom_range(0, 8)) - 64'd4;
      hwe = ($urandom_range(0, 39) == 0);
      lwe = ($urandom_range(0, 29) == 0);
      step($urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0,
           4'($urandom) & 4'b1001, hwe, lwe,
           ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFE + 32'($urandom_range(0, 3))
                                       : $urandom, t);
      check("R6 R8 R9 random", 32'(sts_o), 32'(m_sts));
      irq_en_i = 4'($urandom);
      #1;
      check("R11 random", 32'(irq_o), 32'(|(m_sts & irq_en_i)));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule